// File: doc/BRIEF.md
# Four-Channel Register Readback over I2C

This block is the two-wire serial slave of a small four-channel, 8-bit register bank. A bus master writes a channel value by addressing the slave for writing, sending a control byte and then the data. To read a channel back, the master addresses the slave for writing, sends a control byte and then issues a repeated START. It then addresses the slave again with the read bit set and clocks out the reply. The control byte names the channel. It also carries a flag that lengthens the reply: when the flag is set, a power-down status byte comes before the channel's data.

SCL and SDA enter as plain samples. They are synchronized to the system clock, which must run at least about ten times faster than SCL. START, STOP and the clock edges are found from the synchronized samples. The slave drives SDA only through an open-drain enable (`sda_oe`, 1 pulls the line low). It never stretches the clock.

Top module: `i2c_chan_readback`

## Requirements
- R1: The slave answers only an address byte whose bits [7:3] are 1,0,0,1,1, whose bits [2:1] equal `addr_strap` and whose bit 0 is the R/W flag (0 write, 1 read). It acknowledges by pulling SDA low for the ninth clock. On a mismatch it gives no acknowledge and keeps SDA released until the next START.
- R2: The byte after a write address is acknowledged and is the control byte. Bits [2:1] select the channel and bit 0 is the power-down readback flag. Bits [7:3] have no effect.
- R3: In the write phase, with the flag clear, the first byte after the control byte is stored as the selected channel's data. With the flag set, bits [7:6] of the first byte are stored as that channel's power-down code and the second byte is stored as its data. Every write byte is acknowledged, and any further bytes change nothing.
- R4: A read with the latched flag clear returns the selected channel's data byte (MSB first) and then 0x00.
- R5: A read with the latched flag set returns {power-down code, 6'b111111}, then the data byte, then 0x00.
- R6: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.
- R7: `sda_oe` changes only while the synchronized SCL is low.
- R8: A START or STOP in the middle of a byte abandons that byte. A STOP returns the slave to idle. A START begins a new address byte, and the control byte latched earlier stays in force.
- R9: During and after reset `sda_oe` is 0, and every channel's data and power-down code read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL and SDA |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| addr_strap | input | 2 | Board-strapped low address bits |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Readbacks are run with the flag both clear and set, on channels holding zero, a written value and a written power-down code. These runs separate the two- and three-byte replies and show the 0x3F/0xBF status fill. Control bytes with junk in the upper bits, extra write bytes and a second channel show that only the select bits and the byte position steer storage. Address bytes with a wrong strap or a wrong fixed bit, a master NACK after the first reply byte, and STOP or START in the middle of a byte check that the slave goes quiet or restarts cleanly. A per-clock monitor checks that the enable never moves while SCL has been high for several clocks.

// File: rtl/i2c_rb_pkg.sv
`timescale 1ns/1ps
package i2c_rb_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_CH  = 4;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int PD_W    = 2;
  localparam logic [4:0] DEV_ID = 5'b10011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_WDAT,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_IGNORE
  } rb_state_e;
endpackage

// File: rtl/i2c_cond_detect.sv
`timescale 1ns/1ps
module i2c_cond_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_lvl;
      sda_d  <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_chan_bank.sv
`timescale 1ns/1ps
module i2c_chan_bank
  import i2c_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   sel,
  input  logic              data_we,
  input  logic [BYTE_W-1:0] data_wv,
  input  logic              pd_we,
  input  logic [PD_W-1:0]   pd_wv,
  output logic [BYTE_W-1:0] data_rd,
  output logic [PD_W-1:0]   pd_rd
);
  logic [BYTE_W-1:0] data_q [NUM_CH];
  logic [PD_W-1:0]   pd_q   [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[g] <= '0;
        pd_q[g]   <= '0;
      end else begin
        if (data_we && sel == CH_W'(g)) data_q[g] <= data_wv;
        if (pd_we   && sel == CH_W'(g)) pd_q[g]   <= pd_wv;
      end
    end
  end

  assign data_rd = data_q[sel];
  assign pd_rd   = pd_q[sel];

  // R3: one byte position writes one kind of field
  a_r3_one_field_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_we, pd_we}));
endmodule

// File: rtl/i2c_chan_readback.sv
`timescale 1ns/1ps
module i2c_chan_readback
  import i2c_rb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_strap,
  output logic       sda_oe
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_cond_detect #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  rb_state_e         state, after_ack;
  logic              ack_en;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, rx_next, seq_byte;
  logic [CH_W-1:0]   ctrl_sel;
  logic              ctrl_pd;
  logic [1:0]        wr_idx, rd_idx, seq_idx;
  logic              byte_done, addr_hit, data_we, pd_we;
  logic [BYTE_W-1:0] data_rd;
  logic [PD_W-1:0]   pd_rd;

  assign rx_next   = {rx_sh[BYTE_W-2:0], sda_lvl};
  assign byte_done = scl_rise && (bitcnt == LAST_BIT);
  assign addr_hit  = (rx_next[7:1] == {DEV_ID, addr_strap});
  assign data_we   = (state == ST_WDAT) && byte_done && (wr_idx == (ctrl_pd ? 2'd1 : 2'd0));
  assign pd_we     = (state == ST_WDAT) && byte_done && ctrl_pd && (wr_idx == 2'd0);

  i2c_chan_bank u_bank (
    .clk(clk), .rst_n(rst_n), .sel(ctrl_sel),
    .data_we(data_we), .data_wv(rx_next),
    .pd_we(pd_we), .pd_wv(rx_next[BYTE_W-1 -: PD_W]),
    .data_rd(data_rd), .pd_rd(pd_rd)
  );

  // reply byte for the current position in the read sequence
  assign seq_idx = (state == ST_TXACK) ? rd_idx : 2'd0;
  always_comb begin
    seq_byte = '0;
    if (ctrl_pd) begin
      case (seq_idx)
        2'd0:    seq_byte = {pd_rd, {(BYTE_W-PD_W){1'b1}}};
        2'd1:    seq_byte = data_rd;
        default: seq_byte = '0;
      endcase
    end else if (seq_idx == 2'd0) begin
      seq_byte = data_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      ack_en    <= 1'b0;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ctrl_sel  <= '0;
      ctrl_pd   <= 1'b0;
      wr_idx    <= '0;
      rd_idx    <= '0;
      sda_oe    <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_CTRL, ST_WDAT: begin
          if (scl_rise) begin
            rx_sh  <= rx_next;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == LAST_BIT) begin
              case (state)
                ST_ADDR: begin
                  ack_en    <= addr_hit;
                  after_ack <= rx_next[0] ? ST_TX : ST_CTRL;
                end
                ST_CTRL: begin
                  ack_en    <= 1'b1;
                  ctrl_sel  <= rx_next[CH_W:1];
                  ctrl_pd   <= rx_next[0];
                  wr_idx    <= '0;
                  after_ack <= ST_WDAT;
                end
                default: begin
                  ack_en    <= 1'b1;
                  after_ack <= ST_WDAT;
                  if (wr_idx != 2'd3) wr_idx <= wr_idx + 2'd1;
                end
              endcase
            end
          end else if (scl_fall && bitcnt == ACK_SLOT) begin
            bitcnt <= '0;
            if (ack_en) begin
              sda_oe <= 1'b1;
              state  <= ST_RXACK;
            end else begin
              state  <= ST_IGNORE;
            end
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            state  <= after_ack;
            if (after_ack == ST_TX) begin
              tx_sh  <= seq_byte;
              sda_oe <= ~seq_byte[BYTE_W-1];
              rd_idx <= 2'd1;
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_TXACK;
            end else begin
              bitcnt <= bitcnt + 4'd1;
              sda_oe <= ~tx_sh[BYTE_W-2];
              tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise && sda_lvl) begin
            state <= ST_IGNORE;
          end else if (scl_fall) begin
            tx_sh  <= seq_byte;
            sda_oe <= ~seq_byte[BYTE_W-1];
            bitcnt <= '0;
            state  <= ST_TX;
            if (rd_idx != 2'd3) rd_idx <= rd_idx + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end

  // R7: the line is only moved while SCL is low
  a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));

  // R6 / R1: idle or ignoring means released
  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

  // R8: a bus condition always leaves the line released
  a_r8_cond_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe);

  // R9: released while held in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_release: assert (!sda_oe);
    end
  end
endmodule

// File: tb/i2c_chan_readback_tb.sv
`timescale 1ns/1ps
module i2c_chan_readback_tb;
  localparam int Q = 10;
  localparam logic [1:0] STRAP = 2'b01;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  assign sda_line = m_sda & ~sda_oe;

  i2c_chan_readback u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_strap(STRAP), .sda_oe(sda_oe)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mdata [4];
  logic [1:0] mpd   [4];
  bit   quiet = 1'b0;
  int   quiet_viol = 0;
  logic prev_oe = 1'b0;
  int   scl_hi = 0;

  // per-clock monitor: quiet windows and R7 (enable steady while SCL high)
  always @(negedge clk) begin
    if (quiet && sda_oe) quiet_viol++;
    if (sda_oe !== prev_oe) begin
      checks++;
      if (scl && scl_hi >= 4) begin
        errors++;
        $display("FAIL R7 enable moved with SCL high: actual %b expected %b", sda_oe, prev_oe);
      end
    end
    prev_oe = sda_oe;
    scl_hi  = scl ? scl_hi + 1 : 0;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    step(Q/2); m_sda = 1'b1; step(Q/2); scl = 1'b1; step(Q); m_sda = 1'b0; step(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    step(Q/2); m_sda = 1'b0; step(Q/2); scl = 1'b1; step(Q); m_sda = 1'b1; step(Q);
  endtask

  task automatic put_bit(logic b);
    step(Q/2); m_sda = b; step(Q/2); scl = 1'b1; step(Q); scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    step(Q/2); m_sda = 1'b1; step(Q/2); scl = 1'b1; step(Q/2); b = sda_line; step(Q/2); scl = 1'b0;
  endtask

  task automatic put_byte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
  endtask

  function automatic logic [7:0] addr_byte(logic rw);
    return {5'b10011, STRAP, rw};
  endfunction

  task automatic do_write(logic [1:0] ch, bit pdf, logic [1:0] pdv, logic [7:0] dv, bit extra);
    logic a;
    bus_start();
    put_byte(addr_byte(1'b0), a);      chk("R1", 8'(a), 8'h01);
    put_byte({5'b0, ch, pdf}, a);      chk("R2", 8'(a), 8'h01);
    if (pdf) begin
      put_byte({pdv, 6'b0}, a);        chk("R3", 8'(a), 8'h01);
      mpd[ch] = pdv;
    end
    put_byte(dv, a);                   chk("R3", 8'(a), 8'h01);
    mdata[ch] = dv;
    if (extra) begin
      put_byte(8'hFF, a);              chk("R3", 8'(a), 8'h01);
    end
    bus_stop();
  endtask

  task automatic do_read(logic [1:0] ch, bit pdf, logic [4:0] hi, string req);
    logic a;
    logic [7:0] v;
    bus_start();
    put_byte(addr_byte(1'b0), a);      chk(req, 8'(a), 8'h01);
    put_byte({hi, ch, pdf}, a);        chk(req, 8'(a), 8'h01);
    bus_start();
    put_byte(addr_byte(1'b1), a);      chk(req, 8'(a), 8'h01);
    if (pdf) begin
      get_byte(v, 1'b1);               chk(req, v, {mpd[ch], 6'h3F});
    end
    get_byte(v, 1'b1);                 chk(req, v, mdata[ch]);
    get_byte(v, 1'b0);                 chk(req, v, 8'h00);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic a;
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      mdata[i] = 8'h00;
      mpd[i]   = 2'b00;
    end
    step(6);
    chk("R9", 8'(sda_oe), 8'h00);
    rst_n = 1'b1;
    step(6);
    chk("R9", 8'(sda_oe), 8'h00);

    do_read(2'd0, 1'b0, 5'b0, "R9");                // all-zero bank
    do_read(2'd0, 1'b1, 5'b0, "R9");

    do_write(2'd2, 1'b0, 2'b00, 8'hA5, 1'b0);
    do_read(2'd2, 1'b0, 5'b0, "R4");

    do_write(2'd1, 1'b1, 2'b10, 8'h3C, 1'b0);
    do_read(2'd1, 1'b1, 5'b0, "R5");                 // BF 3C 00
    do_read(2'd2, 1'b1, 5'b0, "R5");                 // 3F A5 00

    do_read(2'd2, 1'b0, 5'b11111, "R2");             // upper control bits ignored

    do_write(2'd3, 1'b0, 2'b00, 8'h5A, 1'b1);        // trailing byte ignored
    do_read(2'd3, 1'b0, 5'b0, "R3");
    do_read(2'd1, 1'b0, 5'b0, "R3");

    // R1: wrong strap, wrong fixed bit
    quiet = 1'b1;
    bus_start();
    put_byte({5'b10011, ~STRAP, 1'b0}, a);  chk("R1", 8'(a), 8'h00);
    put_byte(8'h04, a);                     chk("R1", 8'(a), 8'h00);
    bus_stop();
    bus_start();
    put_byte({5'b10010, STRAP, 1'b1}, a);   chk("R1", 8'(a), 8'h00);
    get_byte(v, 1'b0);                      chk("R1", v, 8'hFF);
    bus_stop();
    quiet = 1'b0;
    chk("R1", 8'(quiet_viol), 8'h00);

    // R6: master NACK after first byte
    bus_start();
    put_byte(addr_byte(1'b0), a);
    put_byte({5'b0, 2'd2, 1'b0}, a);
    bus_start();
    put_byte(addr_byte(1'b1), a);           chk("R6", 8'(a), 8'h01);
    get_byte(v, 1'b0);                      chk("R6", v, 8'hA5);
    quiet = 1'b1;
    get_byte(v, 1'b1);                      chk("R6", v, 8'hFF);
    bus_stop();
    quiet = 1'b0;
    chk("R6", 8'(quiet_viol), 8'h00);

    // R8: STOP mid data byte, START mid control byte
    bus_start();
    put_byte(addr_byte(1'b0), a);
    put_byte({5'b0, 2'd2, 1'b0}, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    step(4);
    chk("R8", 8'(sda_oe), 8'h00);
    bus_start();
    put_byte(addr_byte(1'b0), a);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_start();
    put_byte(addr_byte(1'b1), a);           chk("R8", 8'(a), 8'h01);
    get_byte(v, 1'b1);                      chk("R8", v, 8'hA5);
    get_byte(v, 1'b0);                      chk("R8", v, 8'h00);
    bus_stop();

    step(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule